// File: doc/BRIEF.md
# Texel Address and Fetch Unit

This block turns a stream of texel coordinate requests into reads of a linear 32-bit texture held in external video memory. Each request carries a column `u` and a row `v`. The unit also takes a byte base address, a buffer width and a pixel-storage format code. From these it forms the byte address of the texel and issues a read in the same cycle as the request. When the memory returns the word, the unit presents the color with a response strobe.

The row pitch is counted in blocks of 64 texels, so a buffer width of `W` gives `64·W` texels per row. The memory answers after a fixed number of cycles, set by the parameter `RD_LATENCY`. The unit carries a valid bit and a format-check bit down a pipeline of exactly that depth, so each color leaves in step with its own request. A new request may enter on every cycle. Requests whose format code is not supported still complete, but their color is forced to zero.

Top module: `texel_fetch_unit`

## Requirements
- R1: Format code 6'h00 selects the 32-bit color format at 4 bytes per texel, and the response color for such a request equals the fetched memory word bit for bit.
- R2: The read address equals `base + (v·W·64 + u)·4`, taken modulo 2^32, where `W` is the buffer width.
- R3: `mem_rd_en` is high in exactly the cycles where `req_valid` is high, and `mem_rd_addr` in that cycle is formed from that same cycle's inputs.
- R4: `rsp_valid` rises exactly `RD_LATENCY` clock cycles after the edge that accepts a request.
- R5: Requests may arrive on consecutive cycles, and every request yields exactly one response, in arrival order.
- R6: While `rst_n` is low at a clock edge, every in-flight request is discarded. After reset, `rsp_valid` stays low until a new request has travelled the full latency.
- R7: A request whose format code is anything other than 6'h00 still yields a response after `RD_LATENCY` cycles, with `rsp_color` equal to zero.
- R8: `rsp_color` is zero in every cycle where `rsp_valid` is low.
- R9: A buffer width of zero folds every row onto row 0, so the address becomes `base + 4·u`. A sum that passes 2^32 wraps around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe; a request is accepted on every cycle this is high |
| req_u | input | 11 | Texel column |
| req_v | input | 11 | Texel row |
| base_addr | input | 32 | Byte address of texel (0,0) |
| buf_width | input | 14 | Row pitch in units of 64 texels |
| fmt_code | input | 6 | Pixel-storage format; 6'h00 is 32-bit color |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | 32 | Memory read byte address (the memory uses bits 31:2 as its word index) |
| mem_rd_data | input | 32 | Memory read word, valid `RD_LATENCY` cycles after the read |
| rsp_valid | output | 1 | Response strobe |
| rsp_color | output | 32 | Fetched texel color |

## Verification
Issuing a read and retiring an older response can happen in the same cycle. With a latency of three, a burst of requests on consecutive cycles keeps the read port busy while earlier colors are already leaving. The bench drives such bursts, with valid and invalid format codes mixed, against a memory model whose word is a function of its address. A scoreboard then checks that each response matches its own request in color, order and arrival cycle. A reset asserted while requests are in flight checks that nothing left over appears afterwards.

// File: rtl/texel_fetch_pkg.sv
package texel_fetch_pkg;

   localparam int TFU_COORD_W   = 11;
   localparam int TFU_WIDTH_W   = 14;
   localparam int TFU_ADDR_W    = 32;
   localparam int TFU_DATA_W    = 32;
   localparam int TFU_FMT_W     = 6;
   localparam int TFU_PITCH_LOG2 = 6;

   localparam logic [TFU_FMT_W-1:0] TFU_FMT_COLOR32 = 6'h00;
   localparam int TFU_COLOR32_BYTE_LOG2 = 2;

   typedef struct packed {
      logic vld;
      logic fmt_ok;
   } tfu_stage_t;

endpackage

// File: rtl/tfu_addr_gen.sv
module tfu_addr_gen #(
   parameter int COORD_W    = 11,
   parameter int WIDTH_W    = 14,
   parameter int ADDR_W     = 32,
   parameter int PITCH_LOG2 = 6,
   parameter int BYTE_LOG2  = 2
) (
   input  logic [COORD_W-1:0] u,
   input  logic [COORD_W-1:0] v,
   input  logic [WIDTH_W-1:0] width,
   input  logic [ADDR_W-1:0]  base,
   output logic [ADDR_W-1:0]  byte_addr
);

   localparam int NATIVE_W = COORD_W + WIDTH_W + PITCH_LOG2 + 1;

   initial begin
      if (COORD_W < 1 || WIDTH_W < 1)
         $error("tfu_addr_gen: coordinate and width fields need at least one bit");
      if (PITCH_LOG2 < 0 || BYTE_LOG2 < 0)
         $error("tfu_addr_gen: shift amounts must be non-negative");
      if (ADDR_W < COORD_W + BYTE_LOG2)
         $error("tfu_addr_gen: address too narrow for one row");
   end

   logic [ADDR_W-1:0] u_ext;
   logic [ADDR_W-1:0] v_ext;
   logic [ADDR_W-1:0] pitch;
   logic [ADDR_W-1:0] row_index;
   logic [ADDR_W-1:0] texel_index;
   logic [ADDR_W-1:0] byte_offset;

   always_comb begin
      u_ext       = ADDR_W'(u);
      v_ext       = ADDR_W'(v);
      pitch       = ADDR_W'(width) << PITCH_LOG2;
      row_index   = ADDR_W'(v_ext * pitch);
      texel_index = row_index + u_ext;
      byte_offset = texel_index << BYTE_LOG2;
      byte_addr   = base + byte_offset;
   end

   logic unused_native;
   assign unused_native = (NATIVE_W > 0);

endmodule

// File: rtl/tfu_lat_pipe.sv
module tfu_lat_pipe
   import texel_fetch_pkg::*;
#(
   parameter int DEPTH = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  tfu_stage_t stage_in,
   output tfu_stage_t stage_out
);

   initial begin
      if (DEPTH < 1)
         $error("tfu_lat_pipe: DEPTH must be at least 1");
   end

   tfu_stage_t stage_q [DEPTH];

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  stage_q[gi] <= '0;
               end else begin
                  stage_q[gi] <= stage_in;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  stage_q[gi] <= '0;
               end else begin
                  stage_q[gi] <= stage_q[gi-1];
               end
            end
         end
      end
   endgenerate

   assign stage_out = stage_q[DEPTH-1];

endmodule

// File: rtl/tfu_color_out.sv
module tfu_color_out
   import texel_fetch_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  tfu_stage_t        stage,
   input  logic [DATA_W-1:0] mem_word,
   output logic              valid,
   output logic [DATA_W-1:0] color
);

   always_comb begin
      valid = stage.vld;
      if (stage.vld && stage.fmt_ok) begin
         color = mem_word;
      end else begin
         color = '0;
      end
   end

endmodule

// File: rtl/texel_fetch_unit.sv
module texel_fetch_unit
   import texel_fetch_pkg::*;
#(
   parameter int COORD_W    = TFU_COORD_W,
   parameter int WIDTH_W    = TFU_WIDTH_W,
   parameter int ADDR_W     = TFU_ADDR_W,
   parameter int DATA_W     = TFU_DATA_W,
   parameter int FMT_W      = TFU_FMT_W,
   parameter int PITCH_LOG2 = TFU_PITCH_LOG2,
   parameter int RD_LATENCY = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [COORD_W-1:0] req_u,
   input  logic [COORD_W-1:0] req_v,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [WIDTH_W-1:0] buf_width,
   input  logic [FMT_W-1:0]   fmt_code,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic [DATA_W-1:0]  mem_rd_data,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_color
);

   localparam int BYTE_LOG2 = TFU_COLOR32_BYTE_LOG2;
   localparam int TEXEL_BITS = 8 << BYTE_LOG2;

   initial begin
      if (RD_LATENCY < 1)
         $error("texel_fetch_unit: RD_LATENCY must be at least 1");
      if (DATA_W != TEXEL_BITS)
         $error("texel_fetch_unit: data width must match the 32-bit texel");
      if (FMT_W != TFU_FMT_W)
         $error("texel_fetch_unit: format code width mismatch");
   end

   // Request side: read issued in the accepting cycle.
   logic [ADDR_W-1:0] texel_addr;

   tfu_addr_gen #(
      .COORD_W    (COORD_W),
      .WIDTH_W    (WIDTH_W),
      .ADDR_W     (ADDR_W),
      .PITCH_LOG2 (PITCH_LOG2),
      .BYTE_LOG2  (BYTE_LOG2)
   ) addr_gen_i (
      .u         (req_u),
      .v         (req_v),
      .width     (buf_width),
      .base      (base_addr),
      .byte_addr (texel_addr)
   );

   assign mem_rd_en   = req_valid;
   assign mem_rd_addr = texel_addr;

   // Tag travelling alongside the memory read.
   tfu_stage_t tag_in;
   tfu_stage_t tag_out;

   always_comb begin
      tag_in.vld    = req_valid;
      tag_in.fmt_ok = (fmt_code == FMT_W'(TFU_FMT_COLOR32));
   end

   tfu_lat_pipe #(
      .DEPTH (RD_LATENCY)
   ) lat_pipe_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .stage_in  (tag_in),
      .stage_out (tag_out)
   );

   tfu_color_out #(
      .DATA_W (DATA_W)
   ) color_out_i (
      .stage    (tag_out),
      .mem_word (mem_rd_data),
      .valid    (rsp_valid),
      .color    (rsp_color)
   );

endmodule

// File: rtl/tfu_checker.sv
module tfu_checker #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int FMT_W      = 6,
   parameter int RD_LATENCY = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [FMT_W-1:0]  fmt_code,
   input logic [ADDR_W-1:0] base_addr,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic [DATA_W-1:0] mem_rd_data,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_color
);

   logic [RD_LATENCY-1:0] hist_vld;
   logic [RD_LATENCY-1:0] hist_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_vld <= '0;
         hist_ok  <= '0;
      end else begin
         hist_vld[0] <= req_valid;
         hist_ok[0]  <= (fmt_code == '0);
         for (int k = 1; k < RD_LATENCY; k++) begin
            hist_vld[k] <= hist_vld[k-1];
            hist_ok[k]  <= hist_ok[k-1];
         end
      end
   end

   AST_READ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> mem_rd_en); // R3

   AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_rd_addr[1:0] == base_addr[1:0])); // R2

   AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid == hist_vld[RD_LATENCY-1]); // R4

   AST_COLOR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && hist_ok[RD_LATENCY-1]) |-> (rsp_color == mem_rd_data)); // R1

   AST_BAD_FMT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !hist_ok[RD_LATENCY-1]) |-> (rsp_color == '0)); // R7

   AST_IDLE_COLOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_color == '0)); // R8

   AST_RESET_FLUSH: assert property (@(posedge clk)
      $rose(rst_n) |-> !rsp_valid); // R6

endmodule

bind texel_fetch_unit tfu_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .FMT_W      (FMT_W),
   .RD_LATENCY (RD_LATENCY)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .fmt_code    (fmt_code),
   .base_addr   (base_addr),
   .mem_rd_en   (mem_rd_en),
   .mem_rd_addr (mem_rd_addr),
   .mem_rd_data (mem_rd_data),
   .rsp_valid   (rsp_valid),
   .rsp_color   (rsp_color)
);

// File: tb/texel_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module texel_fetch_unit_tb_top;

   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [10:0] req_u = '0;
   logic [10:0] req_v = '0;
   logic [31:0] base_addr = '0;
   logic [13:0] buf_width = '0;
   logic [5:0]  fmt_code = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic        rsp_valid;
   logic [31:0] rsp_color;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   texel_fetch_unit #(.RD_LATENCY(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_u(req_u),
      .req_v(req_v), .base_addr(base_addr), .buf_width(buf_width),
      .fmt_code(fmt_code), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_color(rsp_color)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return {a[15:0], ~a[31:16]} ^ 32'h5A3C_9617;
   endfunction

   // memory model, LAT registers deep
   logic [31:0] mpipe [LAT];
   always @(posedge clk) begin
      mpipe[0] <= mem_rd_en ? mem_word(mem_rd_addr) : 32'hDEAD_0BAD;
      for (int k = 1; k < LAT; k++) mpipe[k] <= mpipe[k-1];
   end
   assign mem_rd_data = mpipe[LAT-1];

   typedef struct {
      logic [31:0] color;
      int          due;
      string       tag;
   } item_t;
   item_t sb[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // driver: one request per call, leaves req_valid high for chaining
   task automatic issue(input logic [10:0] u, input logic [10:0] v,
                        input logic [13:0] w, input logic [31:0] b,
                        input logic [5:0] f, input string tag);
      logic [31:0] ea;
      item_t it;
      @(negedge clk);
      req_valid = 1'b1; req_u = u; req_v = v; buf_width = w;
      base_addr = b; fmt_code = f;
      ea = b + (((32'(v) * (32'(w) << 6)) + 32'(u)) << 2);
      #1;
      chk(mem_rd_en === 1'b1, "R3 read enable", 32'(mem_rd_en), 32'd1);
      chk(mem_rd_addr === ea, {tag, " address"}, mem_rd_addr, ea);
      it.color = (f == 6'h00) ? mem_word(ea) : 32'h0;
      it.due   = cyc + LAT;
      it.tag   = tag;
      sb.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (rst_n && !done) begin
            if (rsp_valid) begin
               if (sb.size() == 0) begin
                  chk(1'b0, "R5/R6 unexpected response", rsp_color, 32'h0);
               end else begin
                  item_t it;
                  it = sb.pop_front();
                  chk(rsp_color === it.color, {it.tag, " color"}, rsp_color, it.color);
                  chk(cyc == it.due, "R4 latency", 32'(cyc), 32'(it.due));
               end
            end else begin
               chk(rsp_color === 32'h0, "R8 idle color", rsp_color, 32'h0);
               if (sb.size() != 0 && sb[0].due < cyc)
                  chk(1'b0, "R4/R5 missing response", 32'(cyc), 32'(sb[0].due));
               if (sb.size() != 0 && sb[0].due < cyc) void'(sb.pop_front());
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R6 reset rsp_valid", 32'(rsp_valid), 32'd0);
      chk(mem_rd_en === 1'b0, "R3 reset read enable", 32'(mem_rd_en), 32'd0);
      rst_n = 1'b1;

      // single requests, 32-bit format
      issue(11'd3, 11'd2, 14'd1, 32'h0, 6'h00, "R1/R2 single");
      idle();
      repeat (LAT + 1) idle();
      issue(11'd0, 11'd0, 14'd1, 32'h0000_1000, 6'h00, "R1 origin");
      idle();
      repeat (LAT + 1) idle();

      // back-to-back burst with mixed formats
      for (int i = 0; i < 24; i++) begin
         logic [5:0] f;
         f = (i % 5 == 3) ? 6'(i + 1) : 6'h00;
         issue(11'(i * 37 + 5), 11'(i * 13), 14'(i + 2), 32'h0040_0000 + 32'(i * 256),
               f, (f == 6'h00) ? "R5 burst" : "R7 burst bad format");
      end
      idle();
      repeat (LAT + 2) idle();

      // unsupported formats, isolated
      issue(11'd7, 11'd1, 14'd3, 32'h100, 6'h3F, "R7 code 3F");
      issue(11'd9, 11'd4, 14'd3, 32'h100, 6'h01, "R7 code 01");
      idle();
      repeat (LAT + 2) idle();

      // width zero folds rows; wraparound at 2^32
      issue(11'd100, 11'd2047, 14'd0, 32'h0000_2000, 6'h00, "R9 width zero");
      issue(11'd2047, 11'd2047, 14'h3FFF, 32'hFFFF_FF00, 6'h00, "R9 max wrap");
      issue(11'd1, 11'd0, 14'd5, 32'hFFFF_FFFC, 6'h00, "R9 base wrap");
      idle();
      repeat (LAT + 2) idle();

      // reset with requests in flight
      issue(11'd1, 11'd1, 14'd1, 32'h0, 6'h00, "R6 pre-reset");
      issue(11'd2, 11'd1, 14'd1, 32'h0, 6'h00, "R6 pre-reset");
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      sb.delete();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < LAT + 2; k++) begin
         @(negedge clk);
         #3;
         chk(rsp_valid === 1'b0, "R6 flushed after reset", 32'(rsp_valid), 32'd0);
      end
      issue(11'd4, 11'd4, 14'd2, 32'h8000, 6'h00, "R6 post-reset");
      idle();
      repeat (LAT + 2) idle();

      chk(sb.size() == 0, "R5 all responses returned", 32'(sb.size()), 32'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule